// File: doc/BRIEF.md
# Variable Pulse Width Bus Receiver Symbol Decoder

This block sits behind the receive pin of a single-wire, variable-pulse-width serial bus. The raw pin is asynchronous. It passes through a two-stage synchroniser and a run-length glitch filter. The block then measures how long the filtered line stays at each level. The measurement restarts at every transition, so the receiver realigns itself to the transmitter on every symbol and timing error does not build up over a message.

Each completed pulse is sorted by its level and width. A pulse can be noise, a data symbol or a start-of-frame mark. A passive (low) level that lasts too long is caught by two timeouts while it is still in progress: one marks the end of the data and the other marks the end of the whole frame.

A data symbol carries one bit. The bit depends on the level and the width together, not on either one alone. The bits are collected most-significant first and each finished byte is presented with a one-cycle valid strobe. One-cycle strobes also mark start-of-frame, end-of-frame, noise pulses and frames that end with an incomplete byte. All width thresholds are parameters given in clock cycles.

Top module: `vpw_rx_decoder`

## Requirements
- R1: While reset is asserted, and at the first clock after reset is released, all outputs are zero.
- R2: The line is only accepted at a new level after the synchronised input has differed from the accepted level for FILT_LEN consecutive cycles. A shorter excursion produces no output at all.
- R3: A pulse's width is the number of cycles the filtered line held its level. The width count restarts at 1 on every transition. A width of exactly SHORT_MIN_CYC counts as short, exactly LONG_MIN_CYC counts as long, and LONG_MAX_CYC-1 still counts as long.
- R4: An active (high) pulse of at least LONG_MAX_CYC cycles raises sof_o for one cycle. It also discards any bits already collected and opens a frame. A second start mark after an end-of-data gap opens a new frame section without an end-of-frame.
- R5: Inside a frame, a data pulse is short if its width is at least SHORT_MIN_CYC and below LONG_MIN_CYC. It is long if its width is at least LONG_MIN_CYC and below LONG_MAX_CYC. It decodes as follows: passive short = 0, passive long = 1, active short = 1, active long = 0.
- R6: Bits are shifted in most-significant first. After the DATA_W-th bit of a byte, byte_valid_o pulses for one cycle and byte_o shows that byte. byte_o holds its value until the next byte.
- R7: A completed pulse of either level that is shorter than SHORT_MIN_CYC contributes no bit and pulses noise_err_o for one cycle.
- R8: Inside a frame, when a passive level reaches LONG_MAX_CYC cycles (end of data) and the current byte is incomplete, the bits are discarded and frame_err_o pulses for one cycle. If the byte is complete, there is no error.
- R9: Inside a frame, when a passive level reaches EOF_CYC cycles, eof_o pulses for one cycle and the frame closes.
- R10: Outside a frame, data pulses and passive timeouts produce no byte, no eof_o and no frame_err_o.
- R11: In any one cycle, at most one of sof_o, eof_o, byte_valid_o, noise_err_o and frame_err_o is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_i | input | 1 | Raw bus level, asynchronous (1 = active) |
| byte_valid_o | output | 1 | One-cycle strobe: byte_o holds a new byte |
| byte_o | output | DATA_W | Last assembled byte, MSB received first |
| sof_o | output | 1 | One-cycle start-of-frame strobe |
| eof_o | output | 1 | One-cycle end-of-frame strobe |
| noise_err_o | output | 1 | One-cycle strobe for a pulse below the short minimum |
| frame_err_o | output | 1 | One-cycle strobe for an incomplete byte at end of data |

## Verification
The assertions run on every cycle and check the following:
- the filter changes its accepted level only after a full run of differing samples;
- the width count restarts after each edge and otherwise counts up;
- the strobes are mutually exclusive;
- start-of-frame leaves an empty bit counter inside an open frame;
- a framing error only follows a non-empty bit counter;
- bytes only appear inside a frame.

Some behaviour only the bench scenarios can show, because it needs a reference for the expected values. This covers:
- the level-and-width bit mapping;
- MSB-first byte contents;
- the exact cycles of the timeouts;
- the boundary widths;
- the noise pulse that disturbs bit alignment;
- back-to-back start marks;
- bits sent with no start mark.

// File: rtl/vpw_rx_pkg.sv
package vpw_rx_pkg;

    typedef enum logic [2:0] {
        SYM_NONE  = 3'd0,
        SYM_NOISE = 3'd1,
        SYM_BIT   = 3'd2,
        SYM_SOF   = 3'd3,
        SYM_EOD   = 3'd4,
        SYM_EOF   = 3'd5
    } sym_kind_e;

    typedef struct packed {
        sym_kind_e kind;
        logic      bit_val;
    } sym_t;

endpackage

// File: rtl/vpw_rx_sync_filter.sv
module vpw_rx_sync_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic bus_i,
    output logic level_o
);
    localparam int RUN_W = $clog2(FILT_LEN + 1);

    typedef struct packed {
        logic [1:0]       sync;
        logic             filt;
        logic [RUN_W-1:0] run;
    } filt_st_t;

    filt_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[0], bus_i};
        if (st_q.sync[1] != st_q.filt) begin
            if (st_q.run == RUN_W'(FILT_LEN - 1)) begin
                st_d.filt = st_q.sync[1];
                st_d.run  = '0;
            end else begin
                st_d.run = st_q.run + 1'b1;
            end
        end else begin
            st_d.run = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign level_o = st_q.filt;

    AST_FILT_FULL_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.filt != $past(st_q.filt)) |-> ($past(st_q.run) == RUN_W'(FILT_LEN - 1))) // R2
        else $error("filter level changed without a full run");

endmodule

// File: rtl/vpw_rx_width_timer.sv
module vpw_rx_width_timer #(
    parameter int EOD_CYC = 8150,
    parameter int EOF_CYC = 11950
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic                           level_i,
    output logic                           edge_o,
    output logic                           lvl_o,
    output logic [$clog2(EOF_CYC+1)-1:0]   width_o,
    output logic                           eod_hit_o,
    output logic                           eof_hit_o
);
    localparam int W_W = $clog2(EOF_CYC + 1);

    typedef struct packed {
        logic           level;
        logic [W_W-1:0] width;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        edge_o    = (level_i != st_q.level);
        eod_hit_o = !edge_o && !st_q.level && (st_q.width == W_W'(EOD_CYC - 1));
        eof_hit_o = !edge_o && !st_q.level && (st_q.width == W_W'(EOF_CYC - 1));
        st_d      = st_q;
        if (edge_o) begin
            st_d.level = level_i;
            st_d.width = W_W'(1);
        end else if (st_q.width < W_W'(EOF_CYC)) begin
            st_d.width = st_q.width + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{level: 1'b0, width: W_W'(EOF_CYC)};
        else         st_q <= st_d;
    end

    assign lvl_o   = st_q.level;
    assign width_o = st_q.width;

    AST_WIDTH_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
        edge_o |=> (st_q.width == W_W'(1))) // R3
        else $error("width did not restart on a transition");

    AST_WIDTH_COUNTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!edge_o && st_q.width < W_W'(EOF_CYC)) |=> (st_q.width == $past(st_q.width) + 1'b1)) // R3
        else $error("width did not advance while level held");

endmodule

// File: rtl/vpw_rx_sym_classify.sv
module vpw_rx_sym_classify
    import vpw_rx_pkg::*;
#(
    parameter int SHORT_MIN_CYC = 1700,
    parameter int LONG_MIN_CYC  = 4800,
    parameter int LONG_MAX_CYC  = 8150,
    parameter int W_W           = 14
) (
    input  logic           edge_i,
    input  logic           lvl_i,
    input  logic [W_W-1:0] width_i,
    input  logic           eod_hit_i,
    input  logic           eof_hit_i,
    output sym_t           sym_o
);
    always_comb begin
        sym_o = '{kind: SYM_NONE, bit_val: 1'b0};
        if (eof_hit_i) begin
            sym_o.kind = SYM_EOF;
        end else if (eod_hit_i) begin
            sym_o.kind = SYM_EOD;
        end else if (edge_i) begin
            if (width_i < W_W'(SHORT_MIN_CYC)) begin
                sym_o.kind = SYM_NOISE;
            end else if (width_i >= W_W'(LONG_MAX_CYC)) begin
                if (lvl_i) sym_o.kind = SYM_SOF;
            end else begin
                sym_o.kind    = SYM_BIT;
                sym_o.bit_val = lvl_i ^ (width_i >= W_W'(LONG_MIN_CYC));
            end
        end
    end

endmodule

// File: rtl/vpw_rx_decoder.sv
module vpw_rx_decoder
    import vpw_rx_pkg::*;
#(
    parameter int FILT_LEN      = 4,
    parameter int SHORT_MIN_CYC = 1700,
    parameter int LONG_MIN_CYC  = 4800,
    parameter int LONG_MAX_CYC  = 8150,
    parameter int EOF_CYC       = 11950,
    parameter int DATA_W        = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_i,
    output logic              byte_valid_o,
    output logic [DATA_W-1:0] byte_o,
    output logic              sof_o,
    output logic              eof_o,
    output logic              noise_err_o,
    output logic              frame_err_o
);
    localparam int W_W   = $clog2(EOF_CYC + 1);
    localparam int CNT_W = $clog2(DATA_W);

    typedef struct packed {
        logic              in_frame;
        logic [CNT_W-1:0]  bitcnt;
        logic [DATA_W-1:0] shreg;
        logic [DATA_W-1:0] data;
        logic              byte_valid;
        logic              sof;
        logic              eof;
        logic              noise_err;
        logic              frame_err;
    } dec_st_t;

    logic           level;
    logic           edge_s;
    logic           lvl_s;
    logic [W_W-1:0] width_s;
    logic           eod_hit;
    logic           eof_hit;
    sym_t           sym;
    dec_st_t        st_d, st_q;

    vpw_rx_sync_filter #(.FILT_LEN(FILT_LEN)) u_filt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .bus_i  (bus_i),
        .level_o(level)
    );

    vpw_rx_width_timer #(.EOD_CYC(LONG_MAX_CYC), .EOF_CYC(EOF_CYC)) u_tmr (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .level_i  (level),
        .edge_o   (edge_s),
        .lvl_o    (lvl_s),
        .width_o  (width_s),
        .eod_hit_o(eod_hit),
        .eof_hit_o(eof_hit)
    );

    vpw_rx_sym_classify #(
        .SHORT_MIN_CYC(SHORT_MIN_CYC),
        .LONG_MIN_CYC (LONG_MIN_CYC),
        .LONG_MAX_CYC (LONG_MAX_CYC),
        .W_W          (W_W)
    ) u_cls (
        .edge_i   (edge_s),
        .lvl_i    (lvl_s),
        .width_i  (width_s),
        .eod_hit_i(eod_hit),
        .eof_hit_i(eof_hit),
        .sym_o    (sym)
    );

    always_comb begin
        st_d            = st_q;
        st_d.byte_valid = 1'b0;
        st_d.sof        = 1'b0;
        st_d.eof        = 1'b0;
        st_d.noise_err  = 1'b0;
        st_d.frame_err  = 1'b0;
        unique case (sym.kind)
            SYM_NOISE: st_d.noise_err = 1'b1;
            SYM_SOF: begin
                st_d.in_frame = 1'b1;
                st_d.bitcnt   = '0;
                st_d.sof      = 1'b1;
            end
            SYM_BIT: begin
                if (st_q.in_frame) begin
                    st_d.shreg = {st_q.shreg[DATA_W-2:0], sym.bit_val};
                    if (st_q.bitcnt == CNT_W'(DATA_W - 1)) begin
                        st_d.bitcnt     = '0;
                        st_d.data       = {st_q.shreg[DATA_W-2:0], sym.bit_val};
                        st_d.byte_valid = 1'b1;
                    end else begin
                        st_d.bitcnt = st_q.bitcnt + 1'b1;
                    end
                end
            end
            SYM_EOD: begin
                if (st_q.in_frame) begin
                    st_d.frame_err = (st_q.bitcnt != '0);
                    st_d.bitcnt    = '0;
                end
            end
            SYM_EOF: begin
                if (st_q.in_frame) begin
                    st_d.eof      = 1'b1;
                    st_d.in_frame = 1'b0;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign byte_valid_o = st_q.byte_valid;
    assign byte_o       = st_q.data;
    assign sof_o        = st_q.sof;
    assign eof_o        = st_q.eof;
    assign noise_err_o  = st_q.noise_err;
    assign frame_err_o  = st_q.frame_err;

    AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({sof_o, eof_o, byte_valid_o, noise_err_o, frame_err_o})) // R11
        else $error("more than one strobe in a cycle");

    AST_SOF_OPENS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sof_o |-> (st_q.in_frame && st_q.bitcnt == '0)) // R4
        else $error("start mark left a stale bit count");

    AST_FERR_PARTIAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_err_o |-> (st_q.bitcnt == '0 && $past(st_q.bitcnt) != '0)) // R8
        else $error("framing error without a partial byte");

    AST_EOF_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        eof_o |-> (!st_q.in_frame && $past(st_q.in_frame))) // R9
        else $error("end of frame outside a frame");

    AST_BYTE_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
        byte_valid_o |-> st_q.in_frame) // R10
        else $error("byte presented outside a frame");

endmodule

// File: tb/vpw_rx_decoder_tb.sv
module vpw_rx_decoder_tb;
    localparam int FILT = 2;
    localparam int SMIN = 4;
    localparam int LMIN = 10;
    localparam int LMAX = 16;
    localparam int EOFC = 24;
    localparam int SW   = 6;
    localparam int LW   = 13;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus = 1'b0;
    logic       bv, sof, eof, nerr, ferr;
    logic [7:0] bdat;

    always #10 clk = ~clk;

    vpw_rx_decoder #(
        .FILT_LEN(FILT), .SHORT_MIN_CYC(SMIN), .LONG_MIN_CYC(LMIN),
        .LONG_MAX_CYC(LMAX), .EOF_CYC(EOFC), .DATA_W(8)
    ) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .bus_i(bus),
        .byte_valid_o(bv), .byte_o(bdat), .sof_o(sof), .eof_o(eof),
        .noise_err_o(nerr), .frame_err_o(ferr)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // behavioural reference model: run-length view of the delayed line
    int         hist[$];
    bit         mfilt, mlev, infr, mb, medge, allx;
    int         mw, bc;
    logic [7:0] sh, eb;
    bit         ev, es, ee, en, ef;

    always @(posedge clk) begin
        if (!rst_n) begin
            hist = {0, 0, 0, 0, 0, 0, 0, 0};
            mfilt = 0; mlev = 0; mw = EOFC; infr = 0; bc = 0; sh = 0; eb = 0;
            ev = 0; es = 0; ee = 0; en = 0; ef = 0;
        end else begin
            medge = (mfilt != mlev);
            ev = 0; es = 0; ee = 0; en = 0; ef = 0;
            if (!medge && !mlev && mw == EOFC - 1) begin
                if (infr) begin ee = 1; infr = 0; end
            end else if (!medge && !mlev && mw == LMAX - 1) begin
                if (infr) begin ef = (bc != 0); bc = 0; end
            end else if (medge) begin
                if (mw < SMIN) en = 1;
                else if (mw >= LMAX) begin
                    if (mlev) begin es = 1; infr = 1; bc = 0; end
                end else if (infr) begin
                    mb = mlev ^ (mw >= LMIN);
                    sh = {sh[6:0], mb};
                    bc++;
                    if (bc == 8) begin ev = 1; eb = sh; bc = 0; end
                end
            end
            if (medge) begin mlev = mfilt; mw = 1; end
            else if (mw < EOFC) mw++;
            allx = 1;
            for (int i = 0; i < FILT; i++)
                if (hist[hist.size() - 2 - i] == int'(mfilt)) allx = 0;
            if (allx) mfilt = !mfilt;
            hist.push_back(int'(bus));
            void'(hist.pop_front());
        end
    end

    // per-cycle comparison and event collection
    logic [7:0] rxq[$];
    int sof_n, eof_n, nerr_n, ferr_n;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(sof == es,  "R4 sof_o",         sof,  es);
            chk(eof == ee,  "R9 eof_o",         eof,  ee);
            chk(bv == ev,   "R6 byte_valid_o",  bv,   ev);
            chk(bdat == eb, "R5 byte_o",        bdat, eb);
            chk(nerr == en, "R7 noise_err_o",   nerr, en);
            chk(ferr == ef, "R8 frame_err_o",   ferr, ef);
            chk($onehot0({sof, eof, bv, nerr, ferr}), "R11 strobe exclusivity",
                {sof, eof, bv, nerr, ferr}, 0);
            if (bv) rxq.push_back(bdat);
            if (sof) sof_n++;
            if (eof) eof_n++;
            if (nerr) nerr_n++;
            if (ferr) ferr_n++;
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    bit curl = 0;

    task automatic drive(input bit l, input int n);
        bus = l;
        repeat (n) @(negedge clk);
    endtask

    task automatic idle(input int n);
        drive(1'b0, n);
        curl = 1'b1;
    endtask

    task automatic send_sof();
        drive(1'b1, 18);
        curl = 1'b0;
    endtask

    task automatic send_bit(input bit b, input int sw, input int lw);
        drive(curl, (b ^ curl) ? lw : sw);
        curl = ~curl;
    endtask

    task automatic send_byte(input logic [7:0] v, input int sw, input int lw);
        for (int i = 7; i >= 0; i--) send_bit(v[i], sw, lw);
    endtask

    task automatic clear();
        rxq.delete();
        sof_n = 0; eof_n = 0; nerr_n = 0; ferr_n = 0;
    endtask

    initial begin
        logic [7:0] exp1[5];
        exp1 = '{8'hA5, 8'h3C, 8'h00, 8'hFF, 8'h81};
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        chk({bv, bdat, sof, eof, nerr, ferr} == '0, "R1 outputs in reset",
            {bv, bdat, sof, eof, nerr, ferr}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({bv, bdat, sof, eof, nerr, ferr} == '0, "R1 outputs after release",
            {bv, bdat, sof, eof, nerr, ferr}, 0);

        // main frame: all four symbol kinds, R5 R6
        clear(); idle(30);
        send_sof();
        foreach (exp1[i]) send_byte(exp1[i], SW, LW);
        idle(40);
        chk(rxq.size() == 5, "R6 byte count", rxq.size(), 5);
        for (int i = 0; i < 5; i++)
            if (i < rxq.size()) chk(rxq[i] == exp1[i], "R5 byte value", rxq[i], exp1[i]);
        chk(sof_n == 1, "R4 sof count", sof_n, 1);
        chk(eof_n == 1, "R9 eof count", eof_n, 1);
        chk(ferr_n == 0, "R8 no frame error", ferr_n, 0);
        chk(nerr_n == 0, "R7 no noise", nerr_n, 0);

        // glitch filter R2 and noise pulse R7
        clear();
        drive(1'b1, 1); idle(20);
        chk(nerr_n == 0 && sof_n == 0, "R2 one-cycle glitch ignored", nerr_n + sof_n, 0);
        drive(1'b1, 2); idle(20);
        chk(nerr_n == 1, "R7 narrow pulse flagged", nerr_n, 1);

        // boundary widths R3 R5
        clear(); idle(30);
        send_sof();
        send_byte(8'hC6, SMIN, LMIN);
        send_byte(8'h39, SMIN, LMAX - 1);
        idle(40);
        chk(rxq.size() == 2, "R3 boundary byte count", rxq.size(), 2);
        if (rxq.size() == 2) begin
            chk(rxq[0] == 8'hC6, "R3 min widths", rxq[0], 8'hC6);
            chk(rxq[1] == 8'h39, "R3 max long width", rxq[1], 8'h39);
        end

        // partial byte R8
        clear(); idle(30);
        send_sof();
        send_bit(1, SW, LW); send_bit(0, SW, LW); send_bit(1, SW, LW);
        idle(40);
        chk(ferr_n == 1, "R8 partial byte flagged", ferr_n, 1);
        chk(rxq.size() == 0, "R8 partial byte discarded", rxq.size(), 0);
        chk(eof_n == 1, "R9 eof after partial", eof_n, 1);

        // second start after end of data R4
        clear(); idle(30);
        send_sof(); send_byte(8'h5A, SW, LW);
        idle(18);
        send_sof(); send_byte(8'hC3, SW, LW);
        idle(40);
        chk(sof_n == 2, "R4 two start marks", sof_n, 2);
        chk(eof_n == 1, "R9 single eof", eof_n, 1);
        chk(rxq.size() == 2, "R6 two sections", rxq.size(), 2);
        if (rxq.size() == 2) chk(rxq[1] == 8'hC3, "R5 second section byte", rxq[1], 8'hC3);

        // noise inside a frame R7
        clear(); idle(30);
        send_sof(); send_bit(1, SW, LW); send_bit(0, SW, LW);
        drive(1'b0, 3); curl = 1'b1;
        send_byte(8'hE7, SW, LW);
        idle(40);
        chk(nerr_n == 1, "R7 noise in frame", nerr_n, 1);

        // bits with no start mark R10
        clear(); idle(30);
        curl = 1'b1;
        send_byte(8'h55, SW, LW); send_byte(8'hAA, SW, LW);
        idle(40);
        chk(rxq.size() == 0, "R10 no bytes outside frame", rxq.size(), 0);
        chk(eof_n == 0 && ferr_n == 0 && sof_n == 0, "R10 no frame events",
            eof_n + ferr_n + sof_n, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule